// File: doc/BRIEF.md
# Interrupt Entry Save Sequencer

This block carries out the hardware part of taking an interrupt on a small CPU core. When the interrupt controller offers an acknowledge and the block is idle, it accepts the acknowledge and works out the new processor interrupt priority level (IPL) in that same cycle. It then saves the machine context in one of two ways. In the normal mode, the 16-bit flag word and the 24-bit program counter go onto a byte-addressed, downward-growing stack, and the block returns the new stack pointer. In the high-speed mode, both values are copied into two dedicated save registers, and memory and the stack pointer are left alone.

In the normal mode the block writes one byte per cycle. It writes the flag word first, high byte at the top. The program counter follows, zero-extended to 32 bits and written as its upper halfword and then its lower halfword. The flag, PC and stack-pointer inputs are captured on acceptance, so the core may change them while the push is in progress. A one-cycle done pulse marks the end of either mode.

Top module: `intsave_seq`

## Requirements
- R1: When an acknowledge with source code 2'b00 (prioritised source) is accepted, `ipl_wr` is high in that same cycle and `ipl_nxt` equals `ack_lvl`.
- R2: When an acknowledge with source code 2'b01 (watchdog or non-maskable source) is accepted, `ipl_wr` is high and `ipl_nxt` is 7 in that same cycle. With source code 2'b10 (reset source), `ipl_wr` is high and `ipl_nxt` is 0.
- R3: When an acknowledge with source code 2'b11 (other source without a level) is accepted, `ipl_wr` stays low and `ipl_nxt` equals `ipl_in`.
- R4: A normal-mode acceptance (`ack_fast`=0) with stack pointer m produces six byte writes, one per cycle, starting the cycle after acceptance. The writes go to m-1 down to m-6 (modulo 2^24) and carry flag[15:8], flag[7:0], 8'h00, pc[23:16], pc[15:8] and pc[7:0], in that order.
- R5: In the cycle after the sixth write, `sp_wr` pulses for one cycle and `sp_out` equals m-6 (modulo 2^24).
- R6: A high-speed acceptance (`ack_fast`=1) loads `svf` with the flag word and `svp` with the PC at the accepting edge. It causes no memory write and no `sp_wr` pulse, and `done` is high in the next cycle.
- R7: While `busy` is high, `ack_ready` is low and an offered acknowledge is ignored: no `ipl_wr` pulse, and the running push continues with its own data.
- R8: In normal mode, `done` is high for exactly one cycle, in the cycle after the last byte write. `busy` is low in that cycle.
- R9: The synchronous active-low reset clears `svf`, `svp`, `busy`, `done`, `sp_wr` and `mem_we`, including in the middle of a push.
- R10: The flag, PC and stack-pointer values used by a push are the ones present at acceptance. Later changes to those inputs do not alter the written bytes, the addresses or the returned stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ack_valid | input | 1 | Acknowledge offered |
| ack_ready | output | 1 | Block is idle and accepts an acknowledge |
| ack_src | input | 2 | Source class: 00 level, 01 watchdog/NMI, 10 reset, 11 other |
| ack_lvl | input | 3 | Priority level of a prioritised source |
| ack_fast | input | 1 | 1 selects the high-speed register save |
| ipl_in | input | 3 | Current IPL |
| ipl_nxt | output | 3 | IPL value to load |
| ipl_wr | output | 1 | Load `ipl_nxt` into the IPL this cycle |
| sp_in | input | 24 | Current stack pointer |
| flg_in | input | 16 | Current flag word |
| pc_in | input | 24 | Current program counter |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | 24 | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| sp_out | output | 24 | New stack pointer after a push |
| sp_wr | output | 1 | Load `sp_out` into the stack pointer this cycle |
| svf | output | 16 | Flag save register |
| svp | output | 24 | PC save register |
| busy | output | 1 | Push in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The IPL result is combinational, so the bench checks it right after driving the acknowledge, before the accepting edge. The k-th stack byte (k from 0) is due k+1 cycles after that edge. The done, sp_wr and new stack pointer are due seven cycles after it in normal mode and one cycle after it in high-speed mode. Inputs change only on falling edges and every check samples at a falling edge, so each expected value is compared in exactly the cycle it is due, and the cycle on either side is also checked to catch an early or late result.

// File: rtl/intsave_pkg.sv
// Package: shared widths, source-class encoding and fixed IPL values for the
// interrupt entry save sequencer. Assumes flag width is a multiple of 8.
package intsave_pkg;

    localparam int FLG_W  = 16;
    localparam int PC_W   = 24;
    localparam int ADDR_W = 24;
    localparam int IPL_W  = 3;

    // Source class of an acknowledged interrupt
    typedef enum logic [1:0] {
        SRC_LEVEL = 2'b00,
        SRC_WDNMI = 2'b01,
        SRC_RESET = 2'b10,
        SRC_OTHER = 2'b11
    } src_e;

    localparam logic [IPL_W-1:0] IPL_FORCE_HI = IPL_W'(7);
    localparam logic [IPL_W-1:0] IPL_FORCE_LO = IPL_W'(0);

endpackage

// File: rtl/intsave_ipl_rule.sv
// Module: intsave_ipl_rule
// Computes the IPL value to load when an acknowledge is accepted. Purely
// combinational so that the IPL update lands in the accepting cycle.
// Assumes 'take' is already qualified by the idle state of the sequencer.
module intsave_ipl_rule
    import intsave_pkg::*;
#(
    parameter int LW = IPL_W
) (
    input  logic          take,
    input  logic [1:0]    src,
    input  logic [LW-1:0] lvl,
    input  logic [LW-1:0] cur,
    output logic [LW-1:0] nxt,
    output logic          wr
);

    // Choose the new level by source class; classes without a level keep it
    always_comb begin
        nxt = cur;
        wr  = 1'b0;
        if (take) begin
            unique case (src_e'(src))
                SRC_LEVEL: begin nxt = lvl;                wr = 1'b1; end
                SRC_WDNMI: begin nxt = LW'(IPL_FORCE_HI);  wr = 1'b1; end
                SRC_RESET: begin nxt = LW'(IPL_FORCE_LO);  wr = 1'b1; end
                default:   begin nxt = cur;                wr = 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/intsave_push_ctrl.sv
// Module: intsave_push_ctrl
// Writes a captured context frame to a downward stack, one byte per cycle,
// most significant byte first at the highest address. Then reports the new
// stack pointer. Assumes 'start' is only raised while 'busy' is low.
module intsave_push_ctrl #(
    parameter int AW  = 24,
    parameter int FW  = 48,
    localparam int NB = FW / 8,
    localparam int SW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] sp_in,
    input  logic [FW-1:0] frame_in,
    output logic          busy,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [7:0]    wdata,
    output logic          last,
    output logic [AW-1:0] sp_new
);

    logic [SW-1:0] step;
    logic [AW-1:0] sp_lat;
    logic [FW-1:0] frame_lat;

    // Sequence state: capture on start, advance one byte per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            step      <= '0;
            sp_lat    <= '0;
            frame_lat <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            step      <= '0;
            sp_lat    <= sp_in;
            frame_lat <= frame_in;
        end else if (busy) begin
            frame_lat <= frame_lat << 8;
            if (last) begin
                busy <= 1'b0;
                step <= '0;
            end else begin
                step <= step + SW'(1);
            end
        end
    end

    // New stack pointer, registered on the last byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_new <= '0;
        end else if (last) begin
            sp_new <= sp_lat - AW'(NB);
        end
    end

    // Byte port: address counts down from sp-1, data is the frame's top byte
    always_comb begin
        we    = busy;
        addr  = sp_lat - AW'(1) - AW'(step);
        wdata = frame_lat[FW-1 -: 8];
        last  = busy && (step == SW'(NB - 1));
    end

endmodule

// File: rtl/intsave_fast_regs.sv
// Module: intsave_fast_regs
// Holds the flag and PC save registers used by the high-speed sequence.
// Both load together on a fast acceptance and clear on reset.
module intsave_fast_regs #(
    parameter int FLW = 16,
    parameter int PCW = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [FLW-1:0] flg_in,
    input  logic [PCW-1:0] pc_in,
    output logic [FLW-1:0] svf,
    output logic [PCW-1:0] svp
);

    // Save registers: load flag and PC on a fast acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svf <= '0;
            svp <= '0;
        end else if (load) begin
            svf <= flg_in;
            svp <= pc_in;
        end
    end

endmodule

// File: rtl/intsave_seq.sv
// Module: intsave_seq (top)
// Interrupt entry save sequencer: accepts an acknowledge when idle, updates
// the IPL in the accepting cycle, then either pushes flags and the
// zero-extended PC to the stack or copies them into save registers.
// Assumes the core stalls its own stack use while 'busy' is high.
module intsave_seq
    import intsave_pkg::*;
#(
    parameter int FLW = FLG_W,
    parameter int PCW = PC_W,
    parameter int AW  = ADDR_W,
    parameter int LW  = IPL_W,
    localparam int PCX_W = ((PCW + 15) / 16) * 16,
    localparam int FR_W  = FLW + PCX_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ack_valid,
    output logic           ack_ready,
    input  logic [1:0]     ack_src,
    input  logic [LW-1:0]  ack_lvl,
    input  logic           ack_fast,
    input  logic [LW-1:0]  ipl_in,
    output logic [LW-1:0]  ipl_nxt,
    output logic           ipl_wr,
    input  logic [AW-1:0]  sp_in,
    input  logic [FLW-1:0] flg_in,
    input  logic [PCW-1:0] pc_in,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [7:0]     mem_wdata,
    output logic [AW-1:0]  sp_out,
    output logic           sp_wr,
    output logic [FLW-1:0] svf,
    output logic [PCW-1:0] svp,
    output logic           busy,
    output logic           done
);

    logic            take;
    logic            take_push;
    logic            take_fast;
    logic            push_last;
    logic [FR_W-1:0] frame;

    // Acceptance: only while no push is running
    always_comb begin
        ack_ready = !busy;
        take      = ack_valid && ack_ready;
        take_push = take && !ack_fast;
        take_fast = take && ack_fast;
    end

    // Frame: flag word on top, then the PC widened with zero upper bits
    generate
        if (PCX_W > PCW) begin : g_pc_pad
            always_comb frame = {flg_in, {(PCX_W - PCW){1'b0}}, pc_in};
        end else begin : g_pc_nopad
            always_comb frame = {flg_in, pc_in};
        end
    endgenerate

    intsave_ipl_rule #(.LW(LW)) u_ipl (
        .take (take),
        .src  (ack_src),
        .lvl  (ack_lvl),
        .cur  (ipl_in),
        .nxt  (ipl_nxt),
        .wr   (ipl_wr)
    );

    intsave_push_ctrl #(.AW(AW), .FW(FR_W)) u_push (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (take_push),
        .sp_in    (sp_in),
        .frame_in (frame),
        .busy     (busy),
        .we       (mem_we),
        .addr     (mem_addr),
        .wdata    (mem_wdata),
        .last     (push_last),
        .sp_new   (sp_out)
    );

    intsave_fast_regs #(.FLW(FLW), .PCW(PCW)) u_fast (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take_fast),
        .flg_in (flg_in),
        .pc_in  (pc_in),
        .svf    (svf),
        .svp    (svp)
    );

    // End-of-sequence pulses: done for both modes, sp_wr after a push only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            sp_wr <= 1'b0;
        end else begin
            done  <= push_last || take_fast;
            sp_wr <= push_last;
        end
    end

endmodule

// File: rtl/intsave_seq_chk.sv
// Module: intsave_seq_chk
// Property checker for intsave_seq, attached by bind. Tracks the write index
// within a push and the stack pointer captured at acceptance.
module intsave_seq_chk #(
    parameter int AW = 24,
    parameter int LW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_valid,
    input logic          ack_ready,
    input logic [1:0]    ack_src,
    input logic [LW-1:0] ack_lvl,
    input logic          ack_fast,
    input logic [LW-1:0] ipl_in,
    input logic [LW-1:0] ipl_nxt,
    input logic          ipl_wr,
    input logic [AW-1:0] sp_in,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata,
    input logic [AW-1:0] sp_out,
    input logic          sp_wr,
    input logic          busy,
    input logic          done
);

    logic          acc;
    logic [2:0]    wr_idx;
    logic [AW-1:0] sp_cap;

    always_comb acc = ack_valid && ack_ready;

    // Count writes within a contiguous write burst
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_idx <= '0;
        else if (mem_we) wr_idx <= wr_idx + 3'd1;
        else             wr_idx <= '0;
    end

    // Capture the stack pointer at a normal-mode acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)                sp_cap <= '0;
        else if (acc && !ack_fast) sp_cap <= sp_in;
    end

    p_ipl_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && ack_src == 2'b00 |-> ipl_wr && ipl_nxt == ack_lvl);

    p_ipl_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && ack_src == 2'b01 |-> ipl_wr && ipl_nxt == LW'(7));

    p_ipl_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && ack_src == 2'b10 |-> ipl_wr && ipl_nxt == LW'(0));

    p_ipl_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && ack_src == 2'b11 |-> !ipl_wr && ipl_nxt == ipl_in);

    p_addr_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) - AW'(1));

    p_zero_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && wr_idx == 3'd2 |-> mem_wdata == 8'h00);

    p_new_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr |-> sp_out == sp_cap - AW'(6));

    p_fast_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && ack_fast |=> !mem_we && !sp_wr && done);

    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack_ready && !ipl_wr);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !mem_we);

endmodule

bind intsave_seq intsave_seq_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_valid (ack_valid),
    .ack_ready (ack_ready),
    .ack_src   (ack_src),
    .ack_lvl   (ack_lvl),
    .ack_fast  (ack_fast),
    .ipl_in    (ipl_in),
    .ipl_nxt   (ipl_nxt),
    .ipl_wr    (ipl_wr),
    .sp_in     (sp_in),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sp_out    (sp_out),
    .sp_wr     (sp_wr),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_intsave_seq.sv
module tb_intsave_seq;

    localparam int CLK_P = 10;
    localparam int NV    = 8;

    typedef struct packed {
        logic [1:0]  src;
        logic [2:0]  lvl;
        logic        fast;
        logic [2:0]  ipl;
        logic [23:0] sp;
        logic [15:0] flg;
        logic [23:0] pc;
        logic        exp_wr;
        logic [2:0]  exp_ipl;
    } vec_t;

    localparam vec_t VECS [0:NV-1] = '{
        '{2'b00, 3'd5, 1'b0, 3'd2, 24'h001000, 16'hA55A, 24'h123456, 1'b1, 3'd5},
        '{2'b01, 3'd3, 1'b0, 3'd1, 24'h00FFF0, 16'h8001, 24'hFEDCBA, 1'b1, 3'd7},
        '{2'b10, 3'd6, 1'b0, 3'd4, 24'h400000, 16'h0F0F, 24'h00ABCD, 1'b1, 3'd0},
        '{2'b11, 3'd1, 1'b0, 3'd6, 24'h000003, 16'hFFFF, 24'hFFFFFF, 1'b0, 3'd6},
        '{2'b00, 3'd0, 1'b1, 3'd7, 24'h002000, 16'h1357, 24'h2468AC, 1'b1, 3'd0},
        '{2'b01, 3'd2, 1'b1, 3'd0, 24'h002000, 16'hBEEF, 24'h0C0FFE, 1'b1, 3'd7},
        '{2'b11, 3'd4, 1'b1, 3'd3, 24'h002000, 16'h4321, 24'h765432, 1'b0, 3'd3},
        '{2'b00, 3'd7, 1'b0, 3'd0, 24'h000000, 16'h00FF, 24'h800001, 1'b1, 3'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ack_valid = 1'b0;
    logic        ack_ready;
    logic [1:0]  ack_src = '0;
    logic [2:0]  ack_lvl = '0;
    logic        ack_fast = 1'b0;
    logic [2:0]  ipl_in = '0;
    logic [2:0]  ipl_nxt;
    logic        ipl_wr;
    logic [23:0] sp_in = '0;
    logic [15:0] flg_in = '0;
    logic [23:0] pc_in = '0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [23:0] sp_out;
    logic        sp_wr;
    logic [15:0] svf;
    logic [23:0] svp;
    logic        busy;
    logic        done;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    intsave_seq dut (
        .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_ready(ack_ready),
        .ack_src(ack_src), .ack_lvl(ack_lvl), .ack_fast(ack_fast),
        .ipl_in(ipl_in), .ipl_nxt(ipl_nxt), .ipl_wr(ipl_wr), .sp_in(sp_in),
        .flg_in(flg_in), .pc_in(pc_in), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .sp_out(sp_out), .sp_wr(sp_wr), .svf(svf),
        .svp(svp), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [15:0] f,
                                            input logic [23:0] p, input int k);
        case (k)
            0: return f[15:8];
            1: return f[7:0];
            2: return 8'h00;
            3: return p[23:16];
            4: return p[15:8];
            default: return p[7:0];
        endcase
    endfunction

    // One acceptance; intrude drives a competing ack and scrambled inputs mid-push
    task automatic run_ack(input vec_t v, input bit intrude);
        @(negedge clk);
        ack_valid = 1'b1; ack_src = v.src; ack_lvl = v.lvl; ack_fast = v.fast;
        ipl_in = v.ipl; sp_in = v.sp; flg_in = v.flg; pc_in = v.pc;
        #1;
        chk(ack_ready == 1'b1, "R7 ready when idle", 32'(ack_ready), 32'd1);
        chk(ipl_wr == v.exp_wr, "R1/R2/R3 ipl_wr", 32'(ipl_wr), 32'(v.exp_wr));
        chk(ipl_nxt == v.exp_ipl, "R1/R2/R3 ipl_nxt", 32'(ipl_nxt), 32'(v.exp_ipl));
        @(negedge clk);
        ack_valid = 1'b0;
        if (v.fast) begin
            chk(done == 1'b1, "R6 done after fast", 32'(done), 32'd1);
            chk(svf == v.flg, "R6 svf", 32'(svf), 32'(v.flg));
            chk(svp == v.pc, "R6 svp", 32'(svp), 32'(v.pc));
            chk(!mem_we && !sp_wr, "R6 no write", 32'({mem_we, sp_wr}), 32'd0);
            @(negedge clk);
            chk(done == 1'b0, "R6 done one cycle", 32'(done), 32'd0);
        end else begin
            for (int k = 0; k < 6; k++) begin
                if (intrude) begin
                    ack_valid = (k < 5); ack_src = 2'b01; ack_fast = 1'b0;
                    flg_in = ~v.flg; pc_in = ~v.pc; sp_in = v.sp + 24'h100;
                    #1;
                    if (k < 5) begin
                        chk(ack_ready == 1'b0, "R7 not ready", 32'(ack_ready), 32'd0);
                        chk(ipl_wr == 1'b0, "R7 ack ignored", 32'(ipl_wr), 32'd0);
                    end
                end
                chk(mem_we == 1'b1 && busy, "R4 write strobe", 32'(mem_we), 32'd1);
                chk(mem_addr == v.sp - 24'(k + 1), "R4 address", 32'(mem_addr),
                    32'(v.sp - 24'(k + 1)));
                chk(mem_wdata == exp_byte(v.flg, v.pc, k), "R4/R10 data",
                    32'(mem_wdata), 32'(exp_byte(v.flg, v.pc, k)));
                chk(done == 1'b0, "R8 no early done", 32'(done), 32'd0);
                @(negedge clk);
            end
            ack_valid = 1'b0;
            chk(done == 1'b1 && busy == 1'b0, "R8 done", 32'({done, busy}), 32'b10);
            chk(mem_we == 1'b0, "R4 six writes only", 32'(mem_we), 32'd0);
            chk(sp_wr == 1'b1, "R5 sp_wr", 32'(sp_wr), 32'd1);
            chk(sp_out == v.sp - 24'd6, "R5/R10 sp_out", 32'(sp_out), 32'(v.sp - 24'd6));
            @(negedge clk);
            chk(done == 1'b0 && sp_wr == 1'b0, "R8 one-cycle pulse",
                32'({done, sp_wr}), 32'd0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_we && !sp_wr, "R9 reset outputs",
            32'({busy, done, mem_we, sp_wr}), 32'd0);
        chk(svf == 16'd0 && svp == 24'd0, "R9 reset save regs",
            32'(svf ^ 16'(svp)), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_ack(VECS[i], 1'b0);

        // R7 and R10: competing ack and changing inputs during a push
        run_ack('{2'b00, 3'd4, 1'b0, 3'd1, 24'h008000, 16'hC3A5, 24'h5A5A5A, 1'b1, 3'd4}, 1'b1);

        // R9: reset in the middle of a push after a fast load
        run_ack('{2'b00, 3'd2, 1'b1, 3'd0, 24'h0, 16'h7777, 24'h999999, 1'b1, 3'd2}, 1'b0);
        @(negedge clk);
        ack_valid = 1'b1; ack_src = 2'b11; ack_fast = 1'b0; sp_in = 24'h3000;
        @(negedge clk);
        ack_valid = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R9 push running before reset", 32'(busy), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_we && !done, "R9 mid-push reset",
            32'({busy, mem_we, done}), 32'd0);
        chk(svf == 16'd0 && svp == 24'd0, "R9 save regs cleared",
            32'(svf), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_we && !sp_wr, "R9 no resumed push", 32'({mem_we, sp_wr}), 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule